// File: doc/BRIEF.md
# Parking Bus Arbiter With Self-Grant

This arbiter sits inside a cache controller and shares one address bus with a single processor. While the controller has no use for the bus, the processor stays parked: its grant is held asserted whether or not it is asking for the bus. When the controller needs the bus for an invalidate, the arbiter withdraws that grant. If the processor is in the middle of a transaction at that moment, the arbiter sends it a one-cycle retry. The processor then lets go of the bus at once.

When the bus is seen idle, the arbiter takes it. It drives the shared busy line and issues a one-cycle start pulse. On the next cycle it hands the grant back to the processor, while it still holds the busy line. The busy line is open-drain with a pull-up, so it reads idle only when neither master drives it. A parked processor may start only on a qualified grant, which means grant asserted and busy line idle. It therefore waits until the controller's transaction completes. Invalidate requests that arrive while the controller owns the bus are counted and served one after another once the bus has been released.

A strap sampled during reset selects the mode. With the strap low, the arbiter stays dormant and releases the grant pin so that it can act as an input.

Top module: `park_arb`

## Requirements
- R1: The strap is sampled on every clock edge while reset is held and is ignored afterwards. If the sampled value is 0, `grant_oe` is 0. In that case `cpu_grant`, `cpu_retry`, `abb_drive` and `ctl_ts` stay 0 whatever the other inputs do.
- R2: When enabled, `cpu_grant` is 1 from the first edge after reset with `abb_drive` 0, and it stays 1 while no invalidate is pending, including while the processor runs its own transactions.
- R3: In the parked state, a pending invalidate (`inv_req` high at an edge, or one already queued) makes `cpu_grant` go to 0 on that edge.
- R4: If a processor transaction is in flight when the grant is withdrawn, `cpu_retry` is 1 for exactly the cycle in which the grant first drops. A transaction is in flight if `cpu_ts` was seen and no `txn_done` has followed it, or if `cpu_ts` is high at that same edge. Otherwise `cpu_retry` stays 0.
- R5: After the grant is withdrawn, `abb_drive` and `ctl_ts` rise together on the first edge that follows a cycle in which `cpu_abb_drv` was 0. `ctl_ts` is high for one cycle only.
- R6: `cpu_grant` returns to 1 on the edge after `ctl_ts` rises, while `abb_drive` is still 1.
- R7: `txn_done` high at an edge while the controller owns the bus drops `abb_drive` on that edge, and `cpu_grant` stays 1.
- R8: Invalidates that arrive while the controller owns the bus are queued up to PEND_MAX (default 3). Each queued request is served by a further withdraw-and-take sequence after the bus is released. Requests beyond the limit are discarded.
- R9: `abb_drive` is never 1 in a cycle in which `cpu_abb_drv` is 1, for a processor that starts only on a qualified grant and releases the bus after a retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arb_en_strap | input | 1 | Mode strap, sampled while reset is held |
| inv_req | input | 1 | Invalidate request from the controller, one pulse per request |
| cpu_abb_drv | input | 1 | Processor is driving the shared busy line |
| cpu_ts | input | 1 | Processor transfer-start strobe |
| txn_done | input | 1 | Current bus transaction ends |
| cpu_grant | output | 1 | Grant to the processor |
| grant_oe | output | 1 | Output enable of the grant pin |
| cpu_retry | output | 1 | Retry to the processor's transaction |
| abb_drive | output | 1 | Controller drives the shared busy line |
| ctl_ts | output | 1 | Controller transfer-start pulse |

## Verification
If the mode state is wrong, the fault shows at the ports on the next edge. A grant that stays high after a request, or a start pulse issued while the processor still drives the busy line, is visible one cycle after the cause. A wrong in-flight flag shows as a retry that is missing or stray in the cycle where the grant drops. A queue counter that is off changes the number of take sequences that follow a release, so it is counted over a short window.

// File: rtl/park_arb_pkg.sv
package park_arb_pkg;

  typedef enum logic [1:0] {
    ST_PARK  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_START = 2'd2,
    ST_OWN   = 2'd3
  } arb_state_e;

  // Next value of the pending-invalidate count: saturating increment,
  // decrement on service, unchanged when both or neither happen.
  function automatic logic [7:0] pend_next(input logic [7:0] cnt,
                                           input logic inc,
                                           input logic dec,
                                           input logic [7:0] lim);
    logic [7:0] r;
    r = cnt;
    if (inc && !dec && cnt < lim) r = cnt + 8'd1;
    else if (dec && !inc && cnt != 8'd0) r = cnt - 8'd1;
    return r;
  endfunction

endpackage

// File: rtl/park_arb_strap.sv
module park_arb_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  output logic en
);
  // Strap value is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) en <= strap;
  end
endmodule

// File: rtl/park_arb_track.sv
module park_arb_track #(
  parameter int unsigned PEND_MAX = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic inv_req,
  input  logic cpu_ts,
  input  logic txn_done,
  input  logic withdraw,
  input  logic take,
  output logic pend_any,
  output logic cpu_inflight
);
  import park_arb_pkg::*;

  localparam int unsigned CW = $clog2(PEND_MAX + 1);
  localparam logic [7:0] LIM = 8'(PEND_MAX);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          req_in;

  assign req_in = en && inv_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= CW'(pend_next(8'(cnt_q), req_in, take, LIM));
      if (withdraw)      act_q <= 1'b0;
      else if (cpu_ts)   act_q <= 1'b1;
      else if (txn_done) act_q <= 1'b0;
    end
  end

  assign pend_any     = req_in || (cnt_q != '0);
  assign cpu_inflight = act_q || cpu_ts;

  a_r8_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= PEND_MAX);

  a_r8_queue_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_in && !take && 32'(cnt_q) < PEND_MAX) |=> (cnt_q != '0));
endmodule

// File: rtl/park_arb_fsm.sv
module park_arb_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pend_any,
  input  logic cpu_inflight,
  input  logic bus_busy,
  input  logic txn_done,
  output logic grant,
  output logic retry,
  output logic drive,
  output logic ts,
  output logic withdraw,
  output logic take,
  output logic release_bus
);
  import park_arb_pkg::*;

  arb_state_e st_q;
  logic grant_q, retry_q, drive_q, ts_q;

  assign withdraw    = en && st_q == ST_PARK && pend_any;
  assign take        = en && st_q == ST_WAIT && !bus_busy;
  assign release_bus = en && st_q == ST_OWN && txn_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_PARK;
      grant_q <= 1'b1;
      retry_q <= 1'b0;
      drive_q <= 1'b0;
      ts_q    <= 1'b0;
    end else begin
      retry_q <= 1'b0;
      ts_q    <= 1'b0;
      unique case (st_q)
        ST_PARK: if (withdraw) begin
          st_q    <= ST_WAIT;
          grant_q <= 1'b0;
          retry_q <= cpu_inflight;
        end
        ST_WAIT: if (take) begin
          st_q    <= ST_START;
          drive_q <= 1'b1;
          ts_q    <= 1'b1;
        end
        ST_START: begin
          st_q    <= ST_OWN;
          grant_q <= 1'b1;
        end
        ST_OWN: if (release_bus) begin
          st_q    <= ST_PARK;
          drive_q <= 1'b0;
        end
        default: st_q <= ST_PARK;
      endcase
    end
  end

  assign grant = en && grant_q;
  assign retry = en && retry_q;
  assign drive = en && drive_q;
  assign ts    = en && ts_q;

  a_r1_dormant: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!grant && !retry && !drive && !ts));
  a_r3_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    withdraw |=> !grant);
  a_r4_retry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> (!grant && $fell(grant)));
  a_r5_ts_single: assert property (@(posedge clk) disable iff (!rst_n)
    ts |=> !ts);
  a_r6_repark: assert property (@(posedge clk) disable iff (!rst_n)
    ts |=> (grant && drive));
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_bus |=> (!drive && grant));
endmodule

// File: rtl/park_arb.sv
module park_arb #(
  parameter int unsigned PEND_MAX = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arb_en_strap,
  input  logic inv_req,
  input  logic cpu_abb_drv,
  input  logic cpu_ts,
  input  logic txn_done,
  output logic cpu_grant,
  output logic grant_oe,
  output logic cpu_retry,
  output logic abb_drive,
  output logic ctl_ts
);
  logic en, pend_any, cpu_inflight, bus_busy;
  logic withdraw, take, release_bus;

  // Open-drain busy line with pull-up: reads busy if either master pulls.
  assign bus_busy = cpu_abb_drv || abb_drive;
  assign grant_oe = en;

  park_arb_strap u_strap (
    .clk(clk), .rst_n(rst_n), .strap(arb_en_strap), .en(en)
  );

  park_arb_track #(.PEND_MAX(PEND_MAX)) u_track (
    .clk(clk), .rst_n(rst_n), .en(en), .inv_req(inv_req),
    .cpu_ts(cpu_ts), .txn_done(txn_done), .withdraw(withdraw),
    .take(take), .pend_any(pend_any), .cpu_inflight(cpu_inflight)
  );

  park_arb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .pend_any(pend_any),
    .cpu_inflight(cpu_inflight), .bus_busy(bus_busy), .txn_done(txn_done),
    .grant(cpu_grant), .retry(cpu_retry), .drive(abb_drive), .ts(ctl_ts),
    .withdraw(withdraw), .take(take), .release_bus(release_bus)
  );

  a_r9_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(abb_drive && cpu_abb_drv));
  a_r5_idle_before: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abb_drive) |-> $past(!cpu_abb_drv));
  a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (abb_drive && !release_bus) |=> abb_drive);
endmodule

// File: tb/test_park_arb.sv
module test_park_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b1;
  logic inv_req = 1'b0, cpu_abb = 1'b0, cpu_ts = 1'b0, done = 1'b0;
  logic grant, oe, retry, drive, ts;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  park_arb i_park_arb (
    .clk(clk), .rst_n(rst_n), .arb_en_strap(strap), .inv_req(inv_req),
    .cpu_abb_drv(cpu_abb), .cpu_ts(cpu_ts), .txn_done(done),
    .cpu_grant(grant), .grant_oe(oe), .cpu_retry(retry),
    .abb_drive(drive), .ctl_ts(ts)
  );

  // Row: {inv_req, cpu_abb, cpu_ts, done, exp grant, retry, drive, ts}
  localparam int NV = 24;
  localparam logic [7:0] VEC [NV] = '{
    8'b0000_1000, // R2 parked idle
    8'b0110_1000, // R2 processor starts while parked
    8'b1100_0100, // R3 R4 withdraw with retry
    8'b0100_0000, // processor still releasing
    8'b0000_0011, // R5 take bus
    8'b0000_1010, // R6 re-park while driving
    8'b1000_1010, // R8 request queued while owning
    8'b0001_1000, // R7 release
    8'b0000_0000, // R8 queued request withdraws, no retry
    8'b0000_0011, // R5
    8'b0000_1010, // R6
    8'b0001_1000, // R7
    8'b0000_1000, // R2 queue empty
    8'b1110_0100, // R4 start coincides with withdraw
    8'b0100_0000,
    8'b0000_0011, // R5
    8'b0000_1010, // R6
    8'b0001_1000, // R7
    8'b0110_1000, // R2 processor transaction
    8'b0101_1000, // processor transaction done
    8'b1000_0000, // R4 no retry when nothing in flight
    8'b0000_0011,
    8'b0000_1010,
    8'b0001_1000
  };

  task automatic chk(input logic act, input logic exp, input string tag,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic i, input logic a, input logic s,
                      input logic d);
    @(negedge clk);
    inv_req = i; cpu_abb = a; cpu_ts = s; done = d;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input logic sv);
    @(negedge clk);
    rst_n = 1'b0; strap = sv;
    inv_req = 0; cpu_abb = 0; cpu_ts = 0; done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    strap = ~sv; // changes after reset must not matter
    @(posedge clk);
    #2;
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nts;
    do_reset(1'b1);
    chk(oe, 1'b1, "R1", "grant_oe enabled");
    chk(grant, 1'b1, "R2", "grant after reset");
    chk(drive, 1'b0, "R2", "drive after reset");
    chk(ts | retry, 1'b0, "R2", "ts/retry after reset");

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4]);
      chk(grant, VEC[k][3], "R6", $sformatf("grant row %0d", k));
      chk(retry, VEC[k][2], "R4", $sformatf("retry row %0d", k));
      chk(drive, VEC[k][1], "R7", $sformatf("drive row %0d", k));
      chk(ts,    VEC[k][0], "R5", $sformatf("ts row %0d", k));
    end

    // R3 directed: request from parked idle drops grant at once
    step(1, 0, 0, 0);
    chk(grant, 1'b0, "R3", "grant withdrawn");
    step(0, 0, 0, 0);
    chk(ts, 1'b1, "R5", "take after idle");
    step(0, 0, 0, 0);
    chk(grant & drive, 1'b1, "R6", "grant back while owning");

    // R8: four requests while owning, limit three
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0);
    step(0, 0, 0, 1);
    chk(drive, 1'b0, "R7", "release after done");
    nts = 0;
    for (int k = 0; k < 40; k++) begin
      step(0, 0, 0, drive & ~ts);
      if (ts) nts++;
    end
    chk(nts == 3, 1'b1, "R8", $sformatf("services %0d", nts));
    chk(grant, 1'b1, "R2", "parked after queue drained");

    // R1: dormant mode
    do_reset(1'b0);
    chk(oe, 1'b0, "R1", "grant_oe dormant");
    for (int k = 0; k < 6; k++) begin
      step(k < 2, 0, k == 3, 0);
      chk(grant | retry | drive | ts, 1'b0, "R1",
          $sformatf("dormant outputs cycle %0d", k));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule